// File: doc/BRIEF.md
# RTC Countdown Divider and Periodic Rate Generator

This block runs the binary countdown chain of a real-time clock from a 32.768 kHz clock-enable strobe. A three-bit divider-control field decides whether the chain counts, is held at zero, or is frozen with the oscillator off. The least significant bit of that field plays no part in this decision and is passed out unchanged as a register-bank select.

A four-bit rate field picks one tap of the chain. That tap drives a square-wave pin and also sets a sticky periodic flag once per selected period. Each output has its own enable: one gates the square wave and the other turns the flag into an interrupt request. The same chain also gives a one-cycle pulse once per second, which starts the clock's update logic. Leaving the held state places the first such pulse half a second later.

Top module: `rtc_rate_gen`

## Requirements
- R1: With divCtl[2:1] = 2'b01 the chain advances by one on every clock cycle where tick32k is high, whatever divCtl[0] holds. It does not advance on cycles where tick32k is low.
- R2: With divCtl[2:1] = 2'b11 the chain is held at zero. No flag sets, no second pulse occurs, and sqwOut stays low.
- R3: With divCtl[2:1] = 2'b00 or 2'b10 the chain is frozen. The outputs keep their values, no flag or pulse occurs, and counting resumes from the frozen value when the run code returns.
- R4: bankSel always equals divCtl[0].
- R5: For rateSel values 3 to 15, the periodic period is 2^(rateSel-1) ticks. The first flag sets 2^(rateSel-1) ticks after leaving the held state.
- R6: rateSel 1 selects the same rate as 8, and rateSel 2 selects the same rate as 9.
- R7: rateSel 0 sets no flag and holds sqwOut low.
- R8: sqwOut is bit (r-2) of the chain count when sqwEn is 1, where r is the effective rate, and 0 when sqwEn is 0. After leaving the held state it is low for the first half period.
- R9: periodicFlag sets on each period edge whatever pieEn holds. It stays set until a flagClr cycle clears it. A period edge in the same cycle as flagClr leaves the flag set.
- R10: periodicIrq equals periodicFlag AND pieEn.
- R11: secTick is a one-cycle pulse. The first comes 2^14 ticks after leaving the held state, and the following ones come every 2^15 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick32k | input | 1 | 32.768 kHz clock-enable strobe |
| divCtl | input | 3 | Divider control; bit 0 is the bank select |
| rateSel | input | 4 | Rate select shared by both outputs |
| sqwEn | input | 1 | Square-wave enable |
| pieEn | input | 1 | Periodic interrupt enable |
| flagClr | input | 1 | Clears the periodic flag (status read) |
| sqwOut | output | 1 | Square-wave output |
| periodicFlag | output | 1 | Sticky periodic flag |
| periodicIrq | output | 1 | Gated periodic interrupt request |
| secTick | output | 1 | One-per-second update pulse |
| bankSel | output | 1 | Register-bank select |

## Verification
The hardest situations to reach are the phase of the first second pulse after leaving the held state and the collision of a period edge with a clear strobe. Both depend on the exact tick count since the chain left zero. The bench therefore always starts from the held state and then holds tick32k high continuously, so that each clock edge is one tick. It counts edges from release to predict each event exactly, and it times the clear strobe to land on the edge that sets the flag.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;
  localparam int CHAIN_W  = 15;
  localparam int RATE_W   = 4;
  localparam int DIV_W    = 3;
  localparam int SEC_BIT  = CHAIN_W - 1;
  localparam int TAP_OFS  = 2;
  localparam int ALIAS_LO = 8;
  localparam int ALIAS_HI = 9;

  typedef struct packed {
    logic advance;
    logic clearChain;
    logic clearFlag;
  } chainStrobe_t;
endpackage

// File: rtl/rtc_div_ctrl.sv
module rtc_div_ctrl
  import rtc_rate_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick32k,
  input  logic [DIV_W-1:0]        divCtl,
  input  logic [RATE_W-1:0]       rateSel,
  input  logic                    flagClr,
  output chainStrobe_t            strobes,
  output logic [RATE_W-1:0]       tapIdx,
  output logic                    rateOn,
  output logic                    bankSel
);
  localparam logic [1:0] RUN_CODE  = 2'b01;
  localparam logic [1:0] HOLD_CODE = 2'b11;

  logic [1:0]        runField;
  logic [RATE_W-1:0] effRate;

  assign runField = divCtl[DIV_W-1:DIV_W-2];
  assign bankSel  = divCtl[0];

  always_comb begin
    strobes            = '0;
    strobes.advance    = tick32k && (runField == RUN_CODE);
    strobes.clearChain = (runField == HOLD_CODE);
    strobes.clearFlag  = flagClr;
  end

  always_comb begin
    rateOn  = 1'b1;
    effRate = rateSel;
    case (rateSel)
      RATE_W'(0): begin rateOn = 1'b0; effRate = '0; end
      RATE_W'(1): effRate = RATE_W'(ALIAS_LO);
      RATE_W'(2): effRate = RATE_W'(ALIAS_HI);
      default:    effRate = rateSel;
    endcase
    tapIdx = rateOn ? (effRate - RATE_W'(TAP_OFS)) : '0;
  end

  // R1: counting only when enabled and the run code is present
  assert_advance_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |-> (tick32k && divCtl[2:1] == 2'b01));
  // R2: hold and run never asserted together
  assert_hold_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.advance && strobes.clearChain));
endmodule

// File: rtl/rtc_div_path.sv
module rtc_div_path
  import rtc_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chainStrobe_t      strobes,
  input  logic [RATE_W-1:0] tapIdx,
  input  logic              rateOn,
  input  logic              sqwEn,
  output logic              sqwOut,
  output logic              periodicFlag,
  output logic              secTick
);
  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] lowOnes;
  logic               periodEdge;
  logic               secEdge;

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_prefix
    assign lowOnes[i] = &chain[i:0];
  end

  assign periodEdge = strobes.advance && rateOn && lowOnes[tapIdx];
  assign secEdge    = strobes.advance && lowOnes[SEC_BIT-1] && !chain[SEC_BIT];
  assign sqwOut     = sqwEn && rateOn && chain[tapIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else if (strobes.clearChain) begin
      chain <= '0;
    end else if (strobes.advance) begin
      chain <= chain + {{(CHAIN_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodicFlag <= 1'b0;
      secTick      <= 1'b0;
    end else begin
      secTick <= secEdge;
      if (periodEdge)             periodicFlag <= 1'b1;
      else if (strobes.clearFlag) periodicFlag <= 1'b0;
    end
  end

  // R2: the held state forces the chain to zero
  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearChain |=> (chain == '0));
  // R3: no advance and no hold leaves the chain untouched
  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.clearChain) |=> $stable(chain));
  // R9: a new flag only after a counting cycle
  assert_flag_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(periodicFlag) |-> $past(strobes.advance));
  // R9: a clear with no coincident edge drops the flag
  assert_flag_clr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearFlag && !periodEdge) |=> !periodicFlag);
  // R11: the second pulse lands on the half-range boundary
  assert_sec_phase_R11: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> (chain[SEC_BIT-1:0] == '0));
  // R11: pulse is one cycle wide under continuous ticking
  assert_sec_width_R11: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);
endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick32k,
  input  logic [2:0]        divCtl,
  input  logic [3:0]        rateSel,
  input  logic              sqwEn,
  input  logic              pieEn,
  input  logic              flagClr,
  output logic              sqwOut,
  output logic              periodicFlag,
  output logic              periodicIrq,
  output logic              secTick,
  output logic              bankSel
);
  chainStrobe_t      strobes;
  logic [RATE_W-1:0] tapIdx;
  logic              rateOn;

  rtc_div_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick32k (tick32k),
    .divCtl  (divCtl),
    .rateSel (rateSel),
    .flagClr (flagClr),
    .strobes (strobes),
    .tapIdx  (tapIdx),
    .rateOn  (rateOn),
    .bankSel (bankSel)
  );

  rtc_div_path u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .tapIdx       (tapIdx),
    .rateOn       (rateOn),
    .sqwEn        (sqwEn),
    .sqwOut       (sqwOut),
    .periodicFlag (periodicFlag),
    .secTick      (secTick)
  );

  assign periodicIrq = periodicFlag && pieEn;

  // R10: request never raised without its enable
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    periodicIrq |-> (pieEn && periodicFlag));
  // R7: rate zero never produces a square wave
  assert_rate_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == 4'd0) |-> !sqwOut);
endmodule

// File: tb/rtc_rate_gen_tb.sv
module rtc_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick32k;
  logic [2:0] divCtl;
  logic [3:0] rateSel;
  logic       sqwEn, pieEn, flagClr;
  logic       sqwOut, periodicFlag, periodicIrq, secTick, bankSel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_rate_gen u_dut (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .divCtl(divCtl),
    .rateSel(rateSel), .sqwEn(sqwEn), .pieEn(pieEn), .flagClr(flagClr),
    .sqwOut(sqwOut), .periodicFlag(periodicFlag), .periodicIrq(periodicIrq),
    .secTick(secTick), .bankSel(bankSel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Hold the chain at zero and clear the flag, then release with runCode.
  task automatic releaseHold(input logic [2:0] runCode);
    @(negedge clk);
    divCtl  = 3'b110;
    flagClr = 1'b1;
    repeat (3) @(negedge clk);
    flagClr = 1'b0;
    divCtl  = runCode;
  endtask

  task automatic testReset();
    check("reset flag", periodicFlag, 0);
    check("reset sec", secTick, 0);
    check("reset sqw", sqwOut, 0);
    check("reset irq", periodicIrq, 0);
  endtask

  // R5 R6 R9 R10: first and second period edge timing
  task automatic testRate(input logic [3:0] rs, input int period, input logic pie, input string req);
    int n = 0;
    rateSel = rs; pieEn = pie;
    releaseHold(3'b010);
    while (n < 40000) begin
      @(negedge clk); n++;
      if (periodicFlag) break;
    end
    check({req, " first edge"}, n, period);
    check("R10 irq gating", periodicIrq, int'(pie));
    flagClr = 1'b1;
    @(negedge clk); n++;
    flagClr = 1'b0;
    check("R9 clear", periodicFlag, 0);
    while (n < 80000) begin
      @(negedge clk); n++;
      if (periodicFlag) break;
    end
    check({req, " second edge"}, n, 2*period);
  endtask

  // R9: set wins over clear in the same cycle; flag set with pieEn low
  task automatic testCollision();
    rateSel = 4'd3; pieEn = 1'b0;
    releaseHold(3'b010);
    repeat (4) @(negedge clk);
    check("R9 set without pie", periodicFlag, 1);
    check("R10 irq masked", periodicIrq, 0);
    repeat (3) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check("R9 set wins over clear", periodicFlag, 1);
  endtask

  // R8: square wave follows the tap bit
  task automatic testSqw(input logic [3:0] rs);
    int tap = int'(rs) - 2;
    rateSel = rs; sqwEn = 1'b1;
    releaseHold(3'b010);
    for (int m = 1; m <= 40; m++) begin
      @(negedge clk);
      check("R8 square wave", sqwOut, (m >> tap) & 1);
    end
    sqwEn = 1'b0;
    for (int m = 0; m < 10; m++) begin
      @(negedge clk);
      check("R8 sqw disabled", sqwOut, 0);
    end
  endtask

  // R2: held chain stays at zero
  task automatic testHold();
    rateSel = 4'd3; sqwEn = 1'b1;
    releaseHold(3'b110);
    for (int m = 0; m < 30; m++) begin
      @(negedge clk);
      check("R2 hold flag", periodicFlag, 0);
      check("R2 hold sqw", sqwOut, 0);
    end
  endtask

  // R3 R1 R4: freeze and resume, bank bit ignored by run decode
  task automatic testFreeze();
    rateSel = 4'd4; sqwEn = 1'b1;
    releaseHold(3'b010);
    repeat (6) @(negedge clk);
    check("R8 sqw at 6", sqwOut, 1);
    divCtl = 3'b000;
    for (int m = 0; m < 30; m++) begin
      @(negedge clk);
      check("R3 frozen sqw", sqwOut, 1);
      check("R3 frozen flag", periodicFlag, 0);
    end
    divCtl = 3'b101;
    check("R4 bank select", bankSel, 1);
    for (int m = 0; m < 20; m++) begin
      @(negedge clk);
      check("R3 frozen 10x", sqwOut + periodicFlag + secTick, 1);
    end
    divCtl = 3'b011;
    check("R4 bank select run", bankSel, 1);
    @(negedge clk);
    check("R1 resume no flag yet", periodicFlag, 0);
    @(negedge clk);
    check("R1 resume with DV0 set", periodicFlag, 1);
    divCtl = 3'b010;
    check("R4 bank clear", bankSel, 0);
  endtask

  // R7: rate zero gives nothing
  task automatic testRateOff();
    int seen = 0;
    rateSel = 4'd0; sqwEn = 1'b1;
    releaseHold(3'b010);
    for (int m = 0; m < 20000; m++) begin
      @(negedge clk);
      seen += periodicFlag + sqwOut;
    end
    check("R7 rate off", seen, 0);
  endtask

  // R1: counting only on enabled cycles (one tick every third clock)
  task automatic testGated();
    int ticks = 0;
    int j = 0;
    rateSel = 4'd3;
    tick32k = 1'b0;
    releaseHold(3'b010);
    while (j < 100) begin
      tick32k = (j % 3 == 0);
      @(negedge clk);
      if (j % 3 == 0) ticks++;
      j++;
      if (periodicFlag) break;
    end
    check("R1 gated ticks", ticks, 4);
    check("R1 gated cycles", j, 10);
    tick32k = 1'b1;
  endtask

  // R11: second pulse phase and spacing
  task automatic testSec();
    int n = 0;
    int first = 0;
    int second = 0;
    int pulses = 0;
    rateSel = 4'd0;
    releaseHold(3'b010);
    while (n < 49200) begin
      @(negedge clk); n++;
      if (secTick) begin
        pulses++;
        if (pulses == 1) first = n;
        if (pulses == 2) second = n;
      end
    end
    check("R11 first pulse", first, 16384);
    check("R11 spacing", second - first, 32768);
    check("R11 pulse count", pulses, 2);
  endtask

  initial begin
    rstN = 1'b0; tick32k = 1'b1; divCtl = 3'b110; rateSel = 4'd0;
    sqwEn = 1'b0; pieEn = 1'b0; flagClr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRate(4'd3, 4, 1'b1, "R5 rate 3");
    testRate(4'd6, 32, 1'b0, "R5 rate 6");
    testRate(4'd11, 1024, 1'b1, "R5 rate 11");
    testRate(4'd1, 128, 1'b1, "R6 alias 1");
    testRate(4'd2, 256, 1'b0, "R6 alias 2");
    testRate(4'd15, 16384, 1'b1, "R5 rate 15");
    testCollision();
    testSqw(4'd4);
    testSqw(4'd5);
    testHold();
    testFreeze();
    testRateOff();
    testGated();
    testSec();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule